// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits beside the ALU of a five-stage in-order integer pipeline. For each of the two source operands of the instruction now in the execute stage, it decides whether the ALU should take the value read from the register file, the result held in the execute/memory pipeline register, or the value held in the memory/writeback pipeline register. It drives one 2-bit select per operand, and those selects steer the operand multiplexers that sit outside the block.

The block is purely combinational and has no clock. It compares each operand's source register number with the destination register of each later stage. A later stage counts only when its register-write flag is set and its destination is not register zero. When both later stages target the operand's register, the newer result, held in execute/memory, is chosen. A producer three or more instructions ahead needs no bypass, because the register file writes in the first half of the cycle and reads in the second. Stalling after a load and the multiplexers themselves are handled elsewhere.

Top module: `fwd_unit`

## Requirements
- R1: Each select uses only three codes: 2'b00 selects the register-file value, 2'b10 selects the execute/memory result and 2'b01 selects the memory/writeback value. The code 2'b11 never appears.
- R2: An operand's select is 2'b10 when the execute/memory write flag is 1, the execute/memory destination is nonzero, and that destination equals the operand's source register number.
- R3: When R2 does not apply, an operand's select is 2'b01 when the memory/writeback write flag is 1, the memory/writeback destination is nonzero, and that destination equals the operand's source register number.
- R4: When both later stages meet their conditions for the same operand, the select is 2'b10, so the newer result wins. This holds across a chain of back-to-back writes to one register.
- R5: A destination of register 0 never causes a bypass, even when the write flag is set and the source number is also 0.
- R6: Operand A is compared only with the first source field (`src_a`) and operand B only with the second (`src_b`). Each select is decided independently of the other.
- R7: When neither later stage meets its conditions for an operand, that operand's select is 2'b00. This includes the case where a destination matches but its write flag is 0.
- R8: Both selects follow their inputs in the same cycle, with no register stage in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 5 | First source register number of the execute-stage instruction |
| src_b | input | 5 | Second source register number of the execute-stage instruction |
| exm_dst | input | 5 | Destination register number held in execute/memory |
| exm_wen | input | 1 | Register-write flag held in execute/memory |
| mwb_dst | input | 5 | Destination register number held in memory/writeback |
| mwb_wen | input | 1 | Register-write flag held in memory/writeback |
| sel_a | output | 2 | Bypass select for operand A |
| sel_b | output | 2 | Bypass select for operand B |

## Verification
The block holds no state, so a fault shows at the ports in the same cycle that the offending input pattern is applied. A wrong select would feed the ALU a stale or unrelated operand in that instruction's execute cycle. The most telling patterns are these: both stages hitting one register, a register-zero destination with its write flag set, a matching destination whose write flag is clear, and the two operands hitting different stages. A sweep of one operand's source number over every register confirms that the comparators do not alias.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;
  // Select codes for an operand multiplexer; the encoding is fixed.
  typedef enum logic [1:0] {
    FWD_RF = 2'b00,  // register-file value from decode/execute
    FWD_MB = 2'b01,  // value held in memory/writeback
    FWD_EX = 2'b10   // result held in execute/memory
  } fwd_sel_e;
endpackage

// File: rtl/fwd_hit.sv
`timescale 1ns/1ps
// One producer stage against one consumer source field.
module fwd_hit #(
  parameter int REG_W = 5
) (
  input  logic             wen,
  input  logic [REG_W-1:0] dst,
  input  logic [REG_W-1:0] src,
  output logic             hit
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  always_comb begin
    hit = wen && (dst != ZERO_REG) && (dst == src);
  end
endmodule

// File: rtl/fwd_pick.sv
`timescale 1ns/1ps
// Priority choice for one operand: the newer stage wins.
module fwd_pick
  import fwd_pkg::*;
(
  input  logic     ex_hit,
  input  logic     mb_hit,
  output fwd_sel_e sel
);
  always_comb begin
    if (ex_hit)      sel = FWD_EX;
    else if (mb_hit) sel = FWD_MB;
    else             sel = FWD_RF;
  end
endmodule

// File: rtl/fwd_unit.sv
`timescale 1ns/1ps
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic [REG_W-1:0] exm_dst,
  input  logic             exm_wen,
  input  logic [REG_W-1:0] mwb_dst,
  input  logic             mwb_wen,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b
);
  localparam int NUM_SRC = 2;

  logic [REG_W-1:0] src_v [NUM_SRC];
  fwd_sel_e         sel_v [NUM_SRC];

  always_comb begin
    src_v[0] = src_a;
    src_v[1] = src_b;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_opnd
    logic ex_hit;
    logic mb_hit;

    fwd_hit #(.REG_W(REG_W)) u_ex (
      .wen(exm_wen), .dst(exm_dst), .src(src_v[i]), .hit(ex_hit)
    );
    fwd_hit #(.REG_W(REG_W)) u_mb (
      .wen(mwb_wen), .dst(mwb_dst), .src(src_v[i]), .hit(mb_hit)
    );
    fwd_pick u_pick (
      .ex_hit(ex_hit), .mb_hit(mb_hit), .sel(sel_v[i])
    );
  end

  always_comb begin
    sel_a = sel_v[0];
    sel_b = sel_v[1];
  end

  // Port-level checks, evaluated whenever inputs settle.
  always_comb begin
    a_r1_legal_code: assert (sel_a != 2'b11 && sel_b != 2'b11)
      else $error("R1: illegal select code");
    if (exm_dst == '0) begin
      a_r5_zero_dest: assert (sel_a != 2'b10 && sel_b != 2'b10)
        else $error("R5: bypass from register zero");
    end
    if (!exm_wen && !mwb_wen) begin
      a_r7_idle: assert (sel_a == 2'b00 && sel_b == 2'b00)
        else $error("R7: bypass with no writer");
    end
    if (src_a == src_b) begin
      a_r6_same_src: assert (sel_a == sel_b)
        else $error("R6: equal sources gave different selects");
    end
    if (exm_wen && mwb_wen && exm_dst == mwb_dst && exm_dst == src_a && src_a != '0) begin
      a_r4_newest_wins: assert (sel_a == 2'b10)
        else $error("R4: older result preferred");
    end
  end
endmodule

// File: tb/sim_fwd_unit.sv
`timescale 1ns/1ps
module sim_fwd_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;  // 200 MHz

  logic [4:0] src_a, src_b, exm_dst, mwb_dst;
  logic       exm_wen, mwb_wen;
  logic [1:0] sel_a, sel_b;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  fwd_unit u0 (
    .src_a(src_a), .src_b(src_b),
    .exm_dst(exm_dst), .exm_wen(exm_wen),
    .mwb_dst(mwb_dst), .mwb_wen(mwb_wen),
    .sel_a(sel_a), .sel_b(sel_b)
  );

  typedef struct packed {
    logic [4:0] sa;
    logic [4:0] sb;
    logic [4:0] ed;
    logic       ew;
    logic [4:0] md;
    logic       mw;
    logic [1:0] xa;
    logic [1:0] xb;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{5'd1,  5'd2,  5'd1,  1'b0, 5'd2,  1'b0, 2'b00, 2'b00}, // R7 write flags clear
    '{5'd2,  5'd5,  5'd2,  1'b1, 5'd9,  1'b1, 2'b10, 2'b00}, // R2 on A
    '{5'd6,  5'd2,  5'd2,  1'b1, 5'd0,  1'b0, 2'b00, 2'b10}, // R2 on B, R6
    '{5'd6,  5'd2,  5'd13, 1'b1, 5'd2,  1'b1, 2'b00, 2'b01}, // R3 on B
    '{5'd3,  5'd4,  5'd0,  1'b0, 5'd3,  1'b1, 2'b01, 2'b00}, // R3 on A
    '{5'd1,  5'd3,  5'd1,  1'b1, 5'd1,  1'b1, 2'b10, 2'b00}, // R4 both hit A
    '{5'd2,  5'd2,  5'd2,  1'b1, 5'd2,  1'b1, 2'b10, 2'b10}, // R4 both hit both
    '{5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R5 zero dest
    '{5'd0,  5'd7,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R5 zero dest
    '{5'd4,  5'd4,  5'd4,  1'b0, 5'd4,  1'b1, 2'b01, 2'b01}, // R3/R7 ex flag off
    '{5'd8,  5'd9,  5'd8,  1'b1, 5'd9,  1'b1, 2'b10, 2'b01}, // R6 split sources
    '{5'd31, 5'd31, 5'd31, 1'b1, 5'd31, 1'b1, 2'b10, 2'b10}, // R4 top register
    '{5'd0,  5'd5,  5'd0,  1'b1, 5'd5,  1'b1, 2'b00, 2'b01}  // R5 with R3 on B
  };

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] sa, input logic [4:0] sb,
                       input logic [4:0] ed, input logic ew,
                       input logic [4:0] md, input logic mw);
    @(negedge clk);
    src_a = sa; src_b = sb; exm_dst = ed; exm_wen = ew; mwb_dst = md; mwb_wen = mw;
    #1;
  endtask

  // Reference select from the requirement text.
  function automatic logic [1:0] ref_sel(input logic [4:0] s, input logic [4:0] ed,
                                         input logic ew, input logic [4:0] md, input logic mw);
    if (ew && ed != 5'd0 && ed == s) return 2'b10;
    if (mw && md != 5'd0 && md == s) return 2'b01;
    return 2'b00;
  endfunction

  initial begin
    src_a = '0; src_b = '0; exm_dst = '0; exm_wen = 1'b0; mwb_dst = '0; mwb_wen = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset state A", sel_a, 2'b00);
    chk("R7 reset state B", sel_b, 2'b00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].sa, TBL[i].sb, TBL[i].ed, TBL[i].ew, TBL[i].md, TBL[i].mw);
      chk($sformatf("R8 vector %0d A", i), sel_a, TBL[i].xa);
      chk($sformatf("R8 vector %0d B", i), sel_b, TBL[i].xb);
    end

    // R4: chain of back-to-back writes to register 1 (r1 = r1 + rk).
    for (int k = 2; k < 8; k++) begin
      drive(5'd1, 5'(k), 5'd1, 1'b1, 5'd1, 1'b1);
      chk("R4 chain operand A", sel_a, 2'b10);
      chk("R4 chain operand B", sel_b, 2'b00);
    end

    // R6: sweep operand A over every register, B held.
    for (int s = 0; s < 32; s++) begin
      drive(5'(s), 5'd7, 5'd5, 1'b1, 5'd7, 1'b1);
      chk("R6 sweep A", sel_a, ref_sel(5'(s), 5'd5, 1'b1, 5'd7, 1'b1));
      chk("R6 sweep B", sel_b, 2'b01);
    end

    // R1: no code 2'b11 across a second sweep of B.
    for (int s = 0; s < 32; s++) begin
      drive(5'd3, 5'(s), 5'(s), 1'b1, 5'(31 - s), 1'b1);
      total++;
      if (sel_a === 2'b11 || sel_b === 2'b11) begin
        bad++;
        $display("FAIL R1: actual=%b/%b expected=not 11", sel_a, sel_b);
      end
      chk("R2 sweep B", sel_b, ref_sel(5'(s), 5'(s), 1'b1, 5'(31 - s), 1'b1));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule